// File: doc/BRIEF.md
# Carry-less multiply unit

This block forms the carry-less product of two 64-bit operands: the product over GF(2), in which partial products are combined with XOR and no carries propagate. The full product is 128 bits wide, and a half-select input picks which 64-bit half is returned.

The second operand may come from a vector element or from a broadcast scalar. The caller resolves that choice before the inputs, so the block only ever sees two 64-bit values.

The product is built in a pipeline of `STAGES` register stages. Each stage folds a fixed slice of the second operand's bits into a 128-bit accumulator. Operands enter through a valid/ready handshake and results leave through another one. The whole pipeline stalls when the output is held, so results come out in order, one for each accepted operand pair.

Top module: `clmul_unit`

## Requirements
- R1: With `hi_sel_i` = 0, `res_o` equals bits 63..0 of the carry-less product of `opa_i` and `opb_i`. That product is the XOR, over each set bit j of `opb_i`, of `opa_i` shifted left by j.
- R2: With `hi_sel_i` = 1, `res_o` equals bits 127..64 of the same product. Bit 127 is always 0.
- R3: When `opb_i` = 1, the low half equals `opa_i` and the high half is 0.
- R4: When either operand is zero, both halves are zero.
- R5: With `out_ready_i` held at 1, each result appears on `out_valid_o` exactly `STAGES` cycles (4 by default) after its input handshake, and `in_ready_o` stays at 1.
- R6: Every accepted pair yields exactly one result, in acceptance order, under any pattern of `out_ready_i`. While `out_valid_o` = 1 and `out_ready_i` = 0, `res_o` and `out_valid_o` hold.
- R7: After reset, `out_valid_o` is 0 and `in_ready_o` is 1.
- R8: Bit 0 of `opb_i` has no effect on the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair valid |
| in_ready_o | output | 1 | Unit can accept an operand pair |
| opa_i | input | 64 | First operand (x) |
| opb_i | input | 64 | Second operand (y), per element or broadcast |
| hi_sel_i | input | 1 | 0: low half, 1: high half |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer accepts result |
| res_o | output | 64 | Selected half of the product |

## Verification
The bench sweeps every pairing of single-bit operands for both halves. A wrong shift offset in any pipeline slice, or a misplaced half boundary, therefore shows up as a bit at the wrong position. Such an error also breaks the y = 1 identity and the rule that bit 0 of y never reaches the high half.

Zero operands catch an accumulator that is not cleared at entry. If stale state leaks between operations, a zero operand returns a non-zero result.

Random operands are then driven under random backpressure. A pipeline that advances while stalled would drop or duplicate results, or change `res_o` under a held output, and either failure is caught. Directed runs with the output always ready confirm the fixed latency, so an extra or missing register stage is detected.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/clmul_slice.sv
// Folds y bits [OFS +: CH] into a 2W-bit carry-less accumulator.
module clmul_slice #(
  parameter int unsigned W   = 64,
  parameter int unsigned CH  = 16,
  parameter int unsigned OFS = 0
) (
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  input  logic [2*W-1:0] acc_i,
  output logic [2*W-1:0] acc_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] x_ext;
  assign x_ext = {{W{1'b0}}, x_i};

  always_comb begin
    acc_o = acc_i;
    for (int unsigned k = 0; k < CH; k++) begin
      if (y_i[OFS+k]) acc_o = acc_o ^ (x_ext << (OFS + k));
    end
  end
endmodule

// File: rtl/clmul_stage.sv
module clmul_stage
  import clmul_pkg::*;
#(
  parameter int unsigned W   = 64,
  parameter int unsigned CH  = 16,
  parameter int unsigned OFS = 0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           adv_i,
  input  logic           valid_i,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  input  half_e          half_i,
  input  logic [2*W-1:0] acc_i,
  output logic           valid_o,
  output logic [W-1:0]   x_o,
  output logic [W-1:0]   y_o,
  output half_e          half_o,
  output logic [2*W-1:0] acc_o
);
  logic [2*W-1:0] acc_nxt;

  clmul_slice #(.W(W), .CH(CH), .OFS(OFS)) u_slice (
    .x_i  (x_i),
    .y_i  (y_i),
    .acc_i(acc_i),
    .acc_o(acc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      half_o  <= HALF_LO;
      acc_o   <= '0;
    end else if (adv_i) begin
      valid_o <= valid_i;
      if (valid_i) begin
        x_o    <= x_i;
        y_o    <= y_i;
        half_o <= half_i;
        acc_o  <= acc_nxt;
      end
    end
  end

  // R2: top product bit can never be set
  a_r2_top_bit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !acc_o[2*W-1]);

  // R4: zero x keeps the partial sum zero
  a_r4_zero_x: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && x_o == '0) |-> acc_o == '0);

  generate
    if (OFS == 0) begin : g_first
      // R3: y == 1 yields x after the first slice
      a_r3_unit_y: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && y_o == W'(1)) |-> acc_o == {{W{1'b0}}, x_o});
    end
  endgenerate
endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
  import clmul_pkg::*;
#(
  parameter int unsigned W      = 64,
  parameter int unsigned STAGES = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         hi_sel_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned CH  = W / STAGES;
  localparam int unsigned PW  = 2 * W;
  localparam int unsigned CW  = $clog2(STAGES + 2);

  logic          v_a   [0:STAGES];
  logic [W-1:0]  x_a   [0:STAGES];
  logic [W-1:0]  y_a   [0:STAGES];
  half_e         h_a   [0:STAGES];
  logic [PW-1:0] acc_a [0:STAGES];
  logic          adv;

  // whole pipe moves together; stall only when output is held
  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = adv;

  assign v_a[0]   = in_valid_i;
  assign x_a[0]   = opa_i;
  assign y_a[0]   = opb_i;
  assign h_a[0]   = half_e'(hi_sel_i);
  assign acc_a[0] = '0;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      clmul_stage #(.W(W), .CH(CH), .OFS(s * CH)) u_stage (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (adv),
        .valid_i(v_a[s]),
        .x_i    (x_a[s]),
        .y_i    (y_a[s]),
        .half_i (h_a[s]),
        .acc_i  (acc_a[s]),
        .valid_o(v_a[s+1]),
        .x_o    (x_a[s+1]),
        .y_o    (y_a[s+1]),
        .half_o (h_a[s+1]),
        .acc_o  (acc_a[s+1])
      );
    end
  endgenerate

  assign out_valid_o = v_a[STAGES];
  assign res_o = (h_a[STAGES] == HALF_HI) ? acc_a[STAGES][PW-1:W]
                                          : acc_a[STAGES][W-1:0];

  initial a_r1_div: assert (W % STAGES == 0);

  // in-flight tracking for the checks below
  logic [CW-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else inflight_q <= inflight_q + CW'(in_valid_i && in_ready_o)
                                  - CW'(out_valid_o && out_ready_i);
  end

  // R6: held result stays put
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(res_o)));

  // R6: nothing lost or invented
  a_r6_inflight_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CW'(STAGES));

  a_r6_valid_needs_inflight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> inflight_q != '0);

  // R7: idle pipe after reset
  a_r7_idle_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inflight_q == '0) |-> (in_ready_o && !out_valid_o));
endmodule

// File: tb/clmul_unit_test.sv
module clmul_unit_test;
  localparam int W = 64;
  localparam int STAGES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, hi_sel = 1'b0;
  logic [W-1:0] opa = '0, opb = '0, res;
  logic out_valid, out_ready = 1'b1;

  always #5 clk = ~clk;

  clmul_unit #(.W(W), .STAGES(STAGES)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .opa_i(opa), .opb_i(opb), .hi_sel_i(hi_sel),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .res_o(res)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit run = 0, rnd_mode = 0, finished = 0;

  logic [W-1:0] sx_q[$], sy_q[$];
  logic         ss_q[$];
  string        st_q[$];
  logic [W-1:0] ex_q[$];
  string        et_q[$];
  int           ec_q[$];
  bit           el_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b, logic hi);
    logic [2*W-1:0] p = '0;
    for (int i = 0; i < W; i++)
      if (a[i]) p = p ^ ({{W{1'b0}}, b} << i);
    return hi ? p[2*W-1:W] : p[W-1:0];
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic [W-1:0] a, logic [W-1:0] b, logic hi, string tag);
    sx_q.push_back(a); sy_q.push_back(b); ss_q.push_back(hi); st_q.push_back(tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  logic         prev_hold = 0;
  logic [W-1:0] prev_res = '0;

  always @(negedge clk) begin
    if (run) begin
      out_ready <= rnd_mode ? ($urandom % 4 != 0) : 1'b1;
      if (sx_q.size() != 0 && (!rnd_mode || in_valid || ($urandom % 3 != 0))) begin
        in_valid <= 1'b1;
        opa <= sx_q[0]; opb <= sy_q[0]; hi_sel <= ss_q[0];
      end else begin
        in_valid <= 1'b0;
      end
      #1;
      if (prev_hold) begin
        check("R6 hold valid", {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, 1'b1});
        check("R6 hold data", res, prev_res);
      end
      if (out_valid && out_ready) begin
        if (ex_q.size() == 0) begin
          check("R6 extra result", res, '0);
          fails++;
        end else begin
          check(et_q[0], res, ex_q[0]);
          if (el_q[0]) check("R5 latency", W'(cyc - ec_q[0]), W'(STAGES));
          void'(ex_q.pop_front()); void'(et_q.pop_front());
          void'(ec_q.pop_front()); void'(el_q.pop_front());
        end
      end
      if (!rnd_mode) check("R5 in_ready", {{(W-1){1'b0}}, in_ready}, {{(W-1){1'b0}}, 1'b1});
      prev_hold = out_valid && !out_ready;
      prev_res  = res;
      if (in_valid && in_ready) begin
        ex_q.push_back(model(opa, opb, hi_sel));
        et_q.push_back(st_q[0]);
        ec_q.push_back(cyc);
        el_q.push_back(!rnd_mode);
        void'(sx_q.pop_front()); void'(sy_q.pop_front());
        void'(ss_q.pop_front()); void'(st_q.pop_front());
      end
    end
  end

  task automatic drain();
    while (sx_q.size() != 0 || ex_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R7: reset state
    check("R7 out_valid", {{(W-1){1'b0}}, out_valid}, '0);
    check("R7 in_ready", {{(W-1){1'b0}}, in_ready}, {{(W-1){1'b0}}, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    run = 1;

    // R3: unit y
    push(64'h0123_4567_89AB_CDEF, 64'h1, 1'b0, "R3 lo");
    push(64'h0123_4567_89AB_CDEF, 64'h1, 1'b1, "R3 hi");
    push(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, "R3 lo ones");
    push(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, "R3 hi ones");
    // R4: zero operands
    push(64'h0, 64'hDEAD_BEEF_CAFE_F00D, 1'b0, "R4 x0 lo");
    push(64'h0, 64'hDEAD_BEEF_CAFE_F00D, 1'b1, "R4 x0 hi");
    push(64'hDEAD_BEEF_CAFE_F00D, 64'h0, 1'b0, "R4 y0 lo");
    push(64'hDEAD_BEEF_CAFE_F00D, 64'h0, 1'b1, "R4 y0 hi");
    // R8: y bit 0 has no effect on high half
    push(64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 1'b1, "R8 odd");
    push(64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1, "R8 even");
    push(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, "R8 only bit0");
    // R2: largest product
    push(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R2 max hi");
    push(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R1 max lo");
    drain();

    // R1/R2: all single-bit pairs, both halves
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++) begin
        push(W'(1) << i, W'(1) << j, 1'b0, "R1 walk");
        push(W'(1) << i, W'(1) << j, 1'b1, "R2 walk");
      end
    drain();

    // R6: random operands under random backpressure
    rnd_mode = 1;
    for (int n = 0; n < 1500; n++)
      push({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R6 random");
    drain();
    rnd_mode = 0;
    repeat (4) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    finish_run();
  end
endmodule